// File: doc/BRIEF.md
# Per-Port Segment Pool Allocator

This block keeps the books for a shared store of 508 buffer segments that one ingress interface splits among its logical ports. Each segment stands for one data burst. Software programs, through a small register-style configuration port, how many logical ports the interface may use, a segment quota for every port, a free-segment threshold field and an enable bit per port. The datapath then reports each segment it claims or gives back with a per-port allocate or release strobe, and the block answers with a per-port backpressure level and single-cycle error pulses.

Backpressure for a port comes on when the segments still free in its quota fall to or below a threshold. That threshold is the programmed 5-bit field times a scale factor that the block picks from the range the port's own quota falls in, so one small field serves both small and large quotas. Quotas need not be equal, may only be changed while their port is disabled, and can never add up to more than the pool holds. The port-count code can be written once after reset.

Top module: `seg_pool_alloc`

## Requirements
- R1: After reset every quota, threshold field, enable bit and in-use count is zero, the port-count code is 3 (16 ports, quota cap 64), no error output is high, and every bp_o bit is 1 (zero free is at or below a zero threshold).
- R2: The port-count code (cfg_op_i = 0, code in cfg_wdata_i[2:0]) sets the port limit and the per-port quota cap: 0 gives 1 port and 508 segments, 1 gives 4 and 256, 2 gives 8 and 128, 3 gives 16 and 64, 4 gives 32 and 32, 5 gives 64 and 16. Codes 6 and 7 are refused with a cfg_err_o pulse and leave the code unchanged and unlocked.
- R3: The first accepted port-count write after reset locks the code; every later port-count write pulses cfg_err_o and is ignored.
- R4: A quota write (cfg_op_i = 1, value in cfg_wdata_i) to a port whose enable bit is set pulses cfg_err_o and leaves the quota unchanged.
- R5: A quota write to a disabled, in-range port is discarded with an alloc_err_o pulse when the value exceeds the quota cap, is below that port's in-use count, or would bring the sum of all quotas above 508; otherwise it is stored.
- R6: The threshold is N times the 5-bit field (cfg_op_i = 2, value in cfg_wdata_i[4:0]), where N is 16 for a quota of 256 to 508, 8 for 128 to 255, 4 for 64 to 127, 2 for 32 to 63 and 1 for 0 to 31.
- R7: bp_o[p] is 1 exactly when quota minus in-use count of port p is less than or equal to its threshold, and follows each accepted allocate, release or configuration change in the cycle after the clock edge that took it.
- R8: An allocate strobe to an in-range port that is disabled (enable written with cfg_op_i = 3, bit cfg_wdata_i[0]) or whose in-use count equals its quota is refused: the count stays and ovf_err_o[p] pulses the next cycle.
- R9: A release strobe to an in-range port with zero segments in use is ignored and unf_err_o[p] pulses the next cycle.
- R10: Allocate or release strobes to a port at or above the port limit are ignored and pulse lim_err_o[p]; a quota, threshold or enable write to such a port pulses cfg_err_o and changes nothing.
- R11: Allocate and release strobes to the same port in the same cycle are each judged against the count before the edge, so at a full quota the allocate is refused (ovf_err_o pulses) and the release still frees a segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | Write kind: 0 port-count code, 1 quota, 2 threshold field, 3 enable |
| cfg_port_i | input | 6 | Logical port addressed by a quota, threshold or enable write |
| cfg_wdata_i | input | 9 | Write value |
| alloc_req_i | input | 64 | Per-port segment claim strobes |
| rel_req_i | input | 64 | Per-port segment return strobes |
| bp_o | output | 64 | Per-port backpressure |
| ovf_err_o | output | 64 | Per-port refused allocate pulse |
| unf_err_o | output | 64 | Per-port ignored release pulse |
| lim_err_o | output | 64 | Per-port strobe beyond the port limit pulse |
| alloc_err_o | output | 1 | Quota write discarded for lack of room pulse |
| cfg_err_o | output | 1 | Illegal configuration write pulse |

## Verification
Directed sequences fill a quota of 64 with a field of 4 and a quota of 256 with a field of 1, which separates the scale factors at the edge where backpressure must rise, then drive a port to full with a coincident allocate and release to tell the pre-edge judgement from a post-edge one. Quota writes that breach the cap, the in-use count and the pool total are each tried, as are locked and illegal port-count codes. Seeded random strobes and configuration writes under several port-count codes, with ports just past the limit included, compare every output on every cycle with a bench model, which tells apart errors in the count arithmetic, the range gating and the enable gating.

// File: rtl/seg_pool_pkg.sv
package seg_pool_pkg;

  typedef enum logic [1:0] {
    OP_MODE  = 2'd0,
    OP_QUOTA = 2'd1,
    OP_THR   = 2'd2,
    OP_EN    = 2'd3
  } cfg_op_e;

  localparam int LIM_W = 7;
  localparam int CAP_W = 10;
  localparam int SCL_W = 5;
  localparam logic [2:0] CODE_RST = 3'd3;
  localparam logic [2:0] CODE_MAX = 3'd5;

  // number of logical ports the code admits
  function automatic logic [LIM_W-1:0] port_limit(input logic [2:0] code);
    case (code)
      3'd0:    return 7'd1;
      3'd1:    return 7'd4;
      3'd2:    return 7'd8;
      3'd3:    return 7'd16;
      3'd4:    return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  // largest quota one port may hold under the code
  function automatic logic [CAP_W-1:0] quota_cap(input logic [2:0] code);
    case (code)
      3'd0:    return 10'd508;
      3'd1:    return 10'd256;
      3'd2:    return 10'd128;
      3'd3:    return 10'd64;
      3'd4:    return 10'd32;
      default: return 10'd16;
    endcase
  endfunction

  // threshold multiplier picked by the range of the quota
  function automatic logic [SCL_W-1:0] scale_of(input logic [15:0] m);
    if (m >= 16'h0100)      return 5'd16;
    else if (m >= 16'h0080) return 5'd8;
    else if (m >= 16'h0040) return 5'd4;
    else if (m >= 16'h0020) return 5'd2;
    else                    return 5'd1;
  endfunction

endpackage

// File: rtl/spa_mode_reg.sv
module spa_mode_reg
  import seg_pool_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [2:0] code_in_i,
  output logic [2:0] code_o,
  output logic       rej_o
);

  logic [2:0] code_q, code_d;
  logic       lock_q, lock_d;
  logic       take;

  always_comb begin
    rej_o  = wr_i && (lock_q || (code_in_i > CODE_MAX));
    take   = wr_i && !rej_o;
    code_d = code_in_i;
    lock_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_RST;
      lock_q <= 1'b0;
    end else if (take) begin
      code_q <= code_d;
      lock_q <= lock_d;
    end
  end

  assign code_o = code_q;

  p_lock_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock_q |=> $stable(code_q));

  p_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_i && (code_in_i > CODE_MAX) |=> $stable(code_q));

endmodule

// File: rtl/spa_ledger.sv
module spa_ledger
  import seg_pool_pkg::*;
#(
  parameter int QW   = 9,
  parameter int POOL = 508
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [QW-1:0]    new_q_i,
  input  logic [QW-1:0]    old_q_i,
  input  logic [QW-1:0]    used_sel_i,
  input  logic [CAP_W-1:0] cap_i,
  output logic             accept_o,
  output logic             reject_o
);

  localparam int SW = $clog2(POOL + 1) + 2;

  logic [SW-1:0] qsum_q, qsum_d;
  logic          fits_cap, fits_used, fits_pool;

  always_comb begin
    qsum_d    = qsum_q - SW'(old_q_i) + SW'(new_q_i);
    fits_cap  = 32'(new_q_i) <= 32'(cap_i);
    fits_used = new_q_i >= used_sel_i;
    fits_pool = 32'(qsum_d) <= POOL;
    accept_o  = wr_i && fits_cap && fits_used && fits_pool;
    reject_o  = wr_i && !accept_o;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      qsum_q <= '0;
    end else if (accept_o) begin
      qsum_q <= qsum_d;
    end
  end

  p_pool_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    32'(qsum_q) <= POOL);

  p_reject_keeps_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    reject_o |=> $stable(qsum_q));

endmodule

// File: rtl/spa_port.sv
module spa_port
  import seg_pool_pkg::*;
#(
  parameter int QW = 9,
  parameter int TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          in_range_i,
  input  logic          q_wr_i,
  input  logic [QW-1:0] q_new_i,
  input  logic          t_wr_i,
  input  logic [TW-1:0] t_new_i,
  input  logic          e_wr_i,
  input  logic          e_new_i,
  input  logic          alloc_i,
  input  logic          rel_i,
  output logic [QW-1:0] quota_o,
  output logic [QW-1:0] used_o,
  output logic          en_o,
  output logic          bp_o,
  output logic          ovf_err_o,
  output logic          unf_err_o,
  output logic          lim_err_o
);

  logic [QW-1:0] quota_q, used_q, used_d;
  logic [TW-1:0] thr_q;
  logic          en_q;
  logic          ovf_q, unf_q, lim_q;
  logic          ovf_d, unf_d, lim_d;
  logic          room, a_ok, r_ok, used_ce;
  logic [QW-1:0] free_segs;
  logic [31:0]   thr_segs;

  // next state of the occupancy counter and error pulses
  always_comb begin
    room    = en_q && (used_q < quota_q);
    a_ok    = alloc_i && in_range_i && room;
    r_ok    = rel_i && in_range_i && (used_q != '0);
    ovf_d   = alloc_i && in_range_i && !room;
    unf_d   = rel_i && in_range_i && (used_q == '0);
    lim_d   = (alloc_i || rel_i) && !in_range_i;
    used_ce = a_ok ^ r_ok;
    if (a_ok) used_d = used_q + QW'(1);
    else      used_d = used_q - QW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      quota_q <= '0;
      thr_q   <= '0;
      en_q    <= 1'b0;
      used_q  <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      lim_q   <= 1'b0;
    end else begin
      if (q_wr_i)  quota_q <= q_new_i;
      if (t_wr_i)  thr_q   <= t_new_i;
      if (e_wr_i)  en_q    <= e_new_i;
      if (used_ce) used_q  <= used_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      lim_q <= lim_d;
    end
  end

  // backpressure from held state
  always_comb begin
    free_segs = quota_q - used_q;
    thr_segs  = 32'(scale_of(16'(quota_q))) * 32'(thr_q);
    bp_o      = 32'(free_segs) <= thr_segs;
  end

  assign quota_o   = quota_q;
  assign used_o    = used_q;
  assign en_o      = en_q;
  assign ovf_err_o = ovf_q;
  assign unf_err_o = unf_q;
  assign lim_err_o = lim_q;

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    used_q <= quota_q);

  p_refuse_full_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    alloc_i && !rel_i && in_range_i && (used_q == quota_q) |=> $stable(used_q) && ovf_err_o);

  p_release_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    rel_i && in_range_i && (used_q == '0) |=> unf_err_o);

  p_quota_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_q |=> $stable(quota_q));

  p_out_of_range_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alloc_i || rel_i) && !in_range_i |=> $stable(used_q) && lim_err_o);

endmodule

// File: rtl/seg_pool_alloc.sv
module seg_pool_alloc
  import seg_pool_pkg::*;
#(
  parameter int NPORTS = 64,
  parameter int QW     = 9,
  parameter int TW     = 5,
  parameter int POOL   = 508,
  localparam int PW    = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [1:0]        cfg_op_i,
  input  logic [PW-1:0]     cfg_port_i,
  input  logic [QW-1:0]     cfg_wdata_i,
  input  logic [NPORTS-1:0] alloc_req_i,
  input  logic [NPORTS-1:0] rel_req_i,
  output logic [NPORTS-1:0] bp_o,
  output logic [NPORTS-1:0] ovf_err_o,
  output logic [NPORTS-1:0] unf_err_o,
  output logic [NPORTS-1:0] lim_err_o,
  output logic              alloc_err_o,
  output logic              cfg_err_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  cfg_op_e          op;
  logic [2:0]       code;
  logic             mode_rej;
  logic [LIM_W-1:0] limit;
  logic [CAP_W-1:0] cap;
  logic             cfg_in_rng;
  logic             mode_wr, quota_wr;
  logic             q_accept, q_reject;
  logic             cfg_err_d;
  logic             cfg_err_q, alloc_err_q;

  logic [QW-1:0] quota_arr [NPORTS];
  logic [QW-1:0] used_arr  [NPORTS];
  logic          en_arr    [NPORTS];
  logic [QW-1:0] quota_sel, used_sel;
  logic          en_sel;

  assign op         = cfg_op_e'(cfg_op_i);
  assign limit      = port_limit(code);
  assign cap        = quota_cap(code);
  assign cfg_in_rng = 32'(cfg_port_i) < 32'(limit);
  assign quota_sel  = quota_arr[cfg_port_i];
  assign used_sel   = used_arr[cfg_port_i];
  assign en_sel     = en_arr[cfg_port_i];
  assign mode_wr    = cfg_valid_i && (op == OP_MODE);
  assign quota_wr   = cfg_valid_i && (op == OP_QUOTA) && cfg_in_rng && !en_sel;

  spa_mode_reg u_mode (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .wr_i      (mode_wr),
    .code_in_i (cfg_wdata_i[2:0]),
    .code_o    (code),
    .rej_o     (mode_rej)
  );

  spa_ledger #(.QW(QW), .POOL(POOL)) u_ledger (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .wr_i       (quota_wr),
    .new_q_i    (cfg_wdata_i),
    .old_q_i    (quota_sel),
    .used_sel_i (used_sel),
    .cap_i      (cap),
    .accept_o   (q_accept),
    .reject_o   (q_reject)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    logic hit, in_rng;
    assign hit    = cfg_valid_i && cfg_in_rng && (32'(cfg_port_i) == i);
    assign in_rng = i < 32'(limit);

    spa_port #(.QW(QW), .TW(TW)) u_port (
      .clk_i      (clk_i),
      .rst_n      (rst_n),
      .in_range_i (in_rng),
      .q_wr_i     (q_accept && (32'(cfg_port_i) == i)),
      .q_new_i    (cfg_wdata_i),
      .t_wr_i     (hit && (op == OP_THR)),
      .t_new_i    (cfg_wdata_i[TW-1:0]),
      .e_wr_i     (hit && (op == OP_EN)),
      .e_new_i    (cfg_wdata_i[0]),
      .alloc_i    (alloc_req_i[i]),
      .rel_i      (rel_req_i[i]),
      .quota_o    (quota_arr[i]),
      .used_o     (used_arr[i]),
      .en_o       (en_arr[i]),
      .bp_o       (bp_o[i]),
      .ovf_err_o  (ovf_err_o[i]),
      .unf_err_o  (unf_err_o[i]),
      .lim_err_o  (lim_err_o[i])
    );
  end

  always_comb begin
    cfg_err_d = mode_rej
             || (cfg_valid_i && (op != OP_MODE) && !cfg_in_rng)
             || (cfg_valid_i && (op == OP_QUOTA) && cfg_in_rng && en_sel);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err_q   <= 1'b0;
      alloc_err_q <= 1'b0;
    end else begin
      cfg_err_q   <= cfg_err_d;
      alloc_err_q <= q_reject;
    end
  end

  assign cfg_err_o   = cfg_err_q;
  assign alloc_err_o = alloc_err_q;

  p_cfg_range_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_valid_i && (op != OP_MODE) && !cfg_in_rng |=> cfg_err_o && !alloc_err_o);

  p_enabled_quota_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_valid_i && (op == OP_QUOTA) && cfg_in_rng && en_sel |=> cfg_err_o);

  p_err_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(cfg_err_o && alloc_err_o));

endmodule

// File: tb/seg_pool_alloc_tb.sv
`timescale 1ns/1ps
module seg_pool_alloc_tb;

  localparam int NP = 64;
  localparam time TCK = 20ns;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          cfg_valid_i;
  logic [1:0]    cfg_op_i;
  logic [5:0]    cfg_port_i;
  logic [8:0]    cfg_wdata_i;
  logic [NP-1:0] alloc_req_i, rel_req_i;
  logic [NP-1:0] bp_o, ovf_err_o, unf_err_o, lim_err_o;
  logic          alloc_err_o, cfg_err_o;

  int n_chk = 0;
  int n_err = 0;

  int m_code, m_lock;
  int m_q [NP];
  int m_thr [NP];
  int m_en [NP];
  int m_used [NP];

  always #(TCK/2) clk_i = ~clk_i;

  seg_pool_alloc u_dut (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_op_i, .cfg_port_i, .cfg_wdata_i,
    .alloc_req_i, .rel_req_i, .bp_o, .ovf_err_o, .unf_err_o, .lim_err_o,
    .alloc_err_o, .cfg_err_o
  );

  function automatic int f_lim(input int c);
    return (c == 0) ? 1 : (1 << (c + 1));
  endfunction

  function automatic int f_cap(input int c);
    return (c == 0) ? 508 : (512 >> c);
  endfunction

  function automatic int f_scale(input int m);
    if (m >= 256) return 16;
    if (m >= 128) return 8;
    if (m >= 64)  return 4;
    if (m >= 32)  return 2;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive, predict from the model, compare at the next falling edge
  task automatic cyc(input bit v, input int op, input int port, input int wd,
                     input logic [63:0] al, input logic [63:0] rl);
    int lim, cap, qs;
    logic e_cfg, e_ae;
    logic [63:0] e_ovf, e_unf, e_lim, e_bp;
    int nu [NP];
    cfg_valid_i = v; cfg_op_i = op[1:0]; cfg_port_i = port[5:0];
    cfg_wdata_i = wd[8:0]; alloc_req_i = al; rel_req_i = rl;
    lim = f_lim(m_code); cap = f_cap(m_code);
    e_cfg = 1'b0; e_ae = 1'b0;
    for (int p = 0; p < NP; p++) begin
      bit inr, room, aok, rok;
      inr  = p < lim;
      room = (m_en[p] != 0) && (m_used[p] < m_q[p]);
      aok  = al[p] && inr && room;
      rok  = rl[p] && inr && (m_used[p] > 0);
      e_ovf[p] = al[p] && inr && !room;
      e_unf[p] = rl[p] && inr && (m_used[p] == 0);
      e_lim[p] = (al[p] || rl[p]) && !inr;
      nu[p] = m_used[p] + int'(aok) - int'(rok);
    end
    if (v) begin
      case (op)
        0: if (m_lock != 0 || (wd & 7) > 5) e_cfg = 1'b1;
           else begin m_code = wd & 7; m_lock = 1; end
        1: if (port >= lim || m_en[port] != 0) e_cfg = 1'b1;
           else begin
             qs = 0;
             for (int p = 0; p < NP; p++) qs += m_q[p];
             qs = qs - m_q[port] + wd;
             if (wd > cap || wd < m_used[port] || qs > 508) e_ae = 1'b1;
             else m_q[port] = wd;
           end
        2: if (port >= lim) e_cfg = 1'b1; else m_thr[port] = wd % 32;
        default: if (port >= lim) e_cfg = 1'b1; else m_en[port] = wd & 1;
      endcase
    end
    for (int p = 0; p < NP; p++) begin
      m_used[p] = nu[p];
      e_bp[p] = (m_q[p] - m_used[p]) <= f_scale(m_q[p]) * m_thr[p];
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(bp_o == e_bp, "R6 R7 bp_o", bp_o, e_bp);
    chk(ovf_err_o == e_ovf, "R8 ovf_err_o", ovf_err_o, e_ovf);
    chk(unf_err_o == e_unf, "R9 unf_err_o", unf_err_o, e_unf);
    chk(lim_err_o == e_lim, "R10 lim_err_o", lim_err_o, e_lim);
    chk(alloc_err_o == e_ae, "R5 alloc_err_o", 64'(alloc_err_o), 64'(e_ae));
    chk(cfg_err_o == e_cfg, "R4 cfg_err_o", 64'(cfg_err_o), 64'(e_cfg));
  endtask

  task automatic do_cfg(input int op, input int port, input int wd);
    cyc(1'b1, op, port, wd, '0, '0);
  endtask

  task automatic strobe(input int port, input bit a, input bit r);
    logic [63:0] av, rv;
    av = '0; rv = '0;
    av[port] = a; rv[port] = r;
    cyc(1'b0, 0, 0, 0, av, rv);
  endtask

  task automatic do_reset();
    cfg_valid_i = 1'b0; cfg_op_i = '0; cfg_port_i = '0; cfg_wdata_i = '0;
    alloc_req_i = '0; rel_req_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    m_code = 3; m_lock = 0;
    for (int p = 0; p < NP; p++) begin
      m_q[p] = 0; m_thr[p] = 0; m_en[p] = 0; m_used[p] = 0;
    end
  endtask

  task automatic rand_run(input int n);
    for (int k = 0; k < n; k++) begin
      bit v;
      int op, port, wd, span;
      logic [63:0] al, rl;
      v    = ($urandom % 4) == 0;
      op   = $urandom % 4;
      span = f_lim(m_code) + 2;
      port = $urandom % ((span > NP) ? NP : span);
      case (op)
        0: wd = $urandom % 8;
        1: wd = ($urandom % 512) >> ($urandom % 5);
        2: wd = $urandom % 32;
        default: wd = (($urandom % 3) != 0) ? 1 : 0;
      endcase
      for (int p = 0; p < NP; p++) begin
        al[p] = ($urandom % 4) == 0;
        rl[p] = ($urandom % 6) == 0;
      end
      cyc(v, op, port, wd, al, rl);
    end
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk(bp_o == '1, "R1 bp_o", bp_o, '1);
    chk((ovf_err_o | unf_err_o | lim_err_o) == '0, "R1 err vectors", ovf_err_o | unf_err_o | lim_err_o, '0);
    chk({alloc_err_o, cfg_err_o} == 2'b00, "R1 err pulses", 64'({alloc_err_o, cfg_err_o}), 0);

    // R6 quota 64, field 4: threshold 16
    do_cfg(1, 0, 64);
    chk(alloc_err_o == 1'b0 && cfg_err_o == 1'b0, "R5 quota 64 stored", 64'({alloc_err_o, cfg_err_o}), 0);
    do_cfg(2, 0, 4);
    do_cfg(3, 0, 1);
    repeat (47) strobe(0, 1'b1, 1'b0);
    chk(bp_o[0] == 1'b0, "R6 47 used", 64'(bp_o[0]), 0);
    strobe(0, 1'b1, 1'b0);
    chk(bp_o[0] == 1'b1, "R6 R7 48 used", 64'(bp_o[0]), 1);
    repeat (16) strobe(0, 1'b1, 1'b0);
    chk(ovf_err_o[0] == 1'b0, "R8 last fits", 64'(ovf_err_o[0]), 0);
    strobe(0, 1'b1, 1'b0);
    chk(ovf_err_o[0] == 1'b1, "R8 full refused", 64'(ovf_err_o[0]), 1);
    // R11 coincident strobes at full
    strobe(0, 1'b1, 1'b1);
    chk(ovf_err_o[0] == 1'b1 && unf_err_o[0] == 1'b0, "R11 alloc refused", 64'({ovf_err_o[0], unf_err_o[0]}), 2);
    strobe(0, 1'b1, 1'b0);
    chk(ovf_err_o[0] == 1'b0, "R11 release took effect", 64'(ovf_err_o[0]), 0);
    strobe(0, 1'b1, 1'b0);
    chk(ovf_err_o[0] == 1'b1, "R11 full again", 64'(ovf_err_o[0]), 1);
    // R4 / R5 quota write rules
    do_cfg(1, 0, 32);
    chk(cfg_err_o == 1'b1, "R4 enabled quota write", 64'(cfg_err_o), 1);
    do_cfg(3, 0, 0);
    do_cfg(1, 0, 65);
    chk(alloc_err_o == 1'b1, "R5 above cap", 64'(alloc_err_o), 1);
    do_cfg(1, 0, 32);
    chk(alloc_err_o == 1'b1, "R5 below used", 64'(alloc_err_o), 1);
    strobe(0, 1'b1, 1'b0);
    chk(ovf_err_o[0] == 1'b1, "R8 disabled refused", 64'(ovf_err_o[0]), 1);
    // R9 and R10
    strobe(1, 1'b0, 1'b1);
    chk(unf_err_o[1] == 1'b1, "R9 empty release", 64'(unf_err_o[1]), 1);
    strobe(16, 1'b1, 1'b0);
    chk(lim_err_o[16] == 1'b1, "R10 port 16 strobe", 64'(lim_err_o[16]), 1);
    do_cfg(2, 16, 1);
    chk(cfg_err_o == 1'b1, "R10 port 16 write", 64'(cfg_err_o), 1);
    // R2 / R3 port-count code
    do_cfg(0, 0, 6);
    chk(cfg_err_o == 1'b1, "R2 code 6", 64'(cfg_err_o), 1);
    do_cfg(0, 0, 1);
    chk(cfg_err_o == 1'b0, "R2 code 1", 64'(cfg_err_o), 0);
    do_cfg(0, 0, 2);
    chk(cfg_err_o == 1'b1, "R3 locked", 64'(cfg_err_o), 1);
    do_cfg(1, 4, 8);
    chk(cfg_err_o == 1'b1, "R2 limit 4", 64'(cfg_err_o), 1);
    do_cfg(1, 1, 256);
    chk(alloc_err_o == 1'b0, "R2 R5 cap 256", 64'(alloc_err_o), 0);
    do_cfg(1, 2, 200);
    chk(alloc_err_o == 1'b1, "R5 pool total", 64'(alloc_err_o), 1);
    do_cfg(1, 2, 188);
    chk(alloc_err_o == 1'b0, "R5 pool exactly full", 64'(alloc_err_o), 0);
    // R6 quota 256, field 1: threshold 16
    do_cfg(2, 1, 1);
    do_cfg(3, 1, 1);
    repeat (239) strobe(1, 1'b1, 1'b0);
    chk(bp_o[1] == 1'b0, "R6 free 17", 64'(bp_o[1]), 0);
    strobe(1, 1'b1, 1'b0);
    chk(bp_o[1] == 1'b1, "R6 free 16", 64'(bp_o[1]), 1);
    rand_run(4000);

    for (int ph = 0; ph < 3; ph++) begin
      int code;
      code = (ph == 0) ? 0 : ((ph == 1) ? 5 : 4);
      do_reset();
      do_cfg(0, 0, code);
      rand_run(3000);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule